// File: doc/BRIEF.md
# Reference Loss Monitor and Priority Selector

This block watches up to four reference clock inputs. Each input arrives already synchronized into a fast monitor clock domain, as a one-cycle edge pulse. For each input, a watcher counts monitor cycles since that reference's last edge. A reference that stays silent for its programmed number of cycles is marked lost. A lost reference is trusted again only after it shows a programmable number of consecutive edges without a new expiry. Set the limit to about one reference period plus two or three monitor cycles.

A selector picks the active reference from the inputs that are enabled and qualified. It uses a 2-bit priority per input, where the larger value wins and a tie goes to the lower index. When the active input is lost, it moves to the best remaining candidate. When no candidate remains, it raises holdover and keeps the last index. A mode input chooses whether a recovered input of strictly higher priority takes over again. Each change of the selected index is marked by a one-cycle pulse.

Top module: `refmon_select`

## Requirements
- R1: During and right after reset, every loss flag is 1, holdover is 1, the selected index is 0 and the switch pulse is 0.
- R2: An enabled input's silence counter returns to 0 on each edge pulse. When `lim` consecutive cycles pass with no edge, `ref_lost_o[i]` becomes 1 on the following cycle. An input whose edges arrive every P cycles with a limit of at least P is never flagged, and a limit of P-1 flags it.
- R3: A lost input clears its loss flag on the edge that completes `qual_edges_i` consecutive edges with no expiry between them. A value of 0 behaves as 1.
- R4: An input with `ref_en_i[i]`=0 reports a loss flag of 1, restarts qualification when enabled again, and is never the selected index while holdover is 0.
- R5: When leaving holdover, or when the active input is lost, the selection takes the qualified input with the largest 2-bit priority (`ref_prio_i[2i+1:2i]`). On equal priority, the lower index wins.
- R6: Loss of the active input moves the selection to the best qualified input in the next cycle.
- R7: With no enabled qualified input, `holdover_o` is 1 and `sel_idx_o` keeps its last value.
- R8: With `revertive_i`=1, a qualified input of strictly higher priority than the active one takes over. With `revertive_i`=0, the selection stays put while the active input remains qualified.
- R9: `switch_pulse_o` is 1 for exactly the cycle in which `sel_idx_o` shows a new value, and 0 otherwise.
- R10: An edge that arrives in the same cycle the counter would expire prevents the loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Monitor clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_edge_i | input | N_REF | One-cycle edge pulse per reference |
| ref_en_i | input | N_REF | Per-reference enable |
| ref_limit_i | input | N_REF*CNT_W | Silence limit per reference, in monitor cycles |
| ref_prio_i | input | N_REF*2 | 2-bit priority per reference, larger wins |
| qual_edges_i | input | QUAL_W | Clean edges needed to requalify |
| revertive_i | input | 1 | 1 allows return to a higher-priority input |
| sel_idx_o | output | IDX_W | Selected reference index |
| ref_lost_o | output | N_REF | Per-reference loss flag |
| holdover_o | output | 1 | No usable reference |
| switch_pulse_o | output | 1 | One-cycle pulse on a selection change |

## Verification
The bench drives edge trains with a period exactly equal to the limit. A design that let expiry beat a coincident edge would flag a healthy clock there, and one that was off by one in the counter would miss the flag when the limit is lowered by one. Two inputs of equal priority are requalified in the same cycle to catch a tie broken toward the higher index. A recovered input is also brought back under both revertive settings, which exposes a selector that always or never reverts. Holdover entry checks that the index is held rather than reset, and the pulse count is matched against the index changes to expose a stretched or missing pulse.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
    localparam int PRIO_W = 2;
    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/refmon_watch.sv
module refmon_watch
    import refmon_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int QUAL_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              edge_i,
    input  logic [CNT_W-1:0]  limit_i,
    input  logic [QUAL_W-1:0] qual_i,
    output logic              lost_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [QUAL_W-1:0] good;
        logic              lost;
    } wst_t;

    wst_t st_d, st_q;
    logic [CNT_W:0]  cnt_inc;
    logic [QUAL_W:0] good_inc;

    always_comb begin
        st_d     = st_q;
        cnt_inc  = {1'b0, st_q.cnt} + 1'b1;
        good_inc = {1'b0, st_q.good} + 1'b1;
        if (!en_i) begin
            st_d.cnt  = '0;
            st_d.good = '0;
            st_d.lost = 1'b1;
        end else if (edge_i) begin
            st_d.cnt = '0;
            if (st_q.lost) begin
                if (good_inc >= {1'b0, qual_i}) begin
                    st_d.lost = 1'b0;
                    st_d.good = '0;
                end else begin
                    st_d.good = good_inc[QUAL_W-1:0];
                end
            end
        end else if (cnt_inc >= {1'b0, limit_i}) begin
            st_d.cnt  = limit_i;
            st_d.good = '0;
            st_d.lost = 1'b1;
        end else begin
            st_d.cnt = cnt_inc[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.cnt  <= '0;
            st_q.good <= '0;
            st_q.lost <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lost_o = st_q.lost;

    a_r4_disabled_is_lost: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> st_q.lost);
    a_r10_edge_beats_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && edge_i && !st_q.lost) |=> !st_q.lost);
    a_r3_requal_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.lost) |-> ($past(edge_i) && $past(en_i)));
endmodule

// File: rtl/refmon_pick.sv
module refmon_pick
    import refmon_pkg::*;
#(
    parameter int N_REF = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_REF-1:0]        qual_i,
    input  logic [N_REF*PRIO_W-1:0] prio_i,
    output logic                    any_o,
    output logic [IDX_W-1:0]        best_o
);
    prio_t best_p;

    always_comb begin
        any_o  = 1'b0;
        best_o = '0;
        best_p = '0;
        for (int i = 0; i < N_REF; i++) begin
            if (qual_i[i] && (!any_o || prio_i[i*PRIO_W +: PRIO_W] > best_p)) begin
                any_o  = 1'b1;
                best_o = IDX_W'(i);
                best_p = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/refmon_select.sv
module refmon_select
    import refmon_pkg::*;
#(
    parameter int N_REF  = 4,
    parameter int CNT_W  = 16,
    parameter int QUAL_W = 4,
    localparam int IDX_W = (N_REF > 1) ? $clog2(N_REF) : 1
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [N_REF-1:0]        ref_edge_i,
    input  logic [N_REF-1:0]        ref_en_i,
    input  logic [N_REF*CNT_W-1:0]  ref_limit_i,
    input  logic [N_REF*PRIO_W-1:0] ref_prio_i,
    input  logic [QUAL_W-1:0]       qual_edges_i,
    input  logic                    revertive_i,
    output logic [IDX_W-1:0]        sel_idx_o,
    output logic [N_REF-1:0]        ref_lost_o,
    output logic                    holdover_o,
    output logic                    switch_pulse_o
);
    typedef struct packed {
        logic [IDX_W-1:0] sel;
        logic             hold;
        logic             pulse;
    } sst_t;

    logic [N_REF-1:0] lost_w;
    logic [N_REF-1:0] qual_w;
    prio_t            prio_a [N_REF];
    logic             any_w;
    logic [IDX_W-1:0] best_w;
    sst_t             st_d, st_q;

    for (genvar g = 0; g < N_REF; g++) begin : g_watch
        refmon_watch #(.CNT_W(CNT_W), .QUAL_W(QUAL_W)) watch_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .en_i    (ref_en_i[g]),
            .edge_i  (ref_edge_i[g]),
            .limit_i (ref_limit_i[g*CNT_W +: CNT_W]),
            .qual_i  (qual_edges_i),
            .lost_o  (lost_w[g])
        );
        assign qual_w[g] = ref_en_i[g] & ~lost_w[g];
        assign prio_a[g] = ref_prio_i[g*PRIO_W +: PRIO_W];
    end

    refmon_pick #(.N_REF(N_REF), .IDX_W(IDX_W)) pick_i (
        .qual_i (qual_w),
        .prio_i (ref_prio_i),
        .any_o  (any_w),
        .best_o (best_w)
    );

    always_comb begin
        st_d = st_q;
        if (!any_w) begin
            st_d.hold = 1'b1;
        end else if (st_q.hold || !qual_w[st_q.sel]) begin
            st_d.sel  = best_w;
            st_d.hold = 1'b0;
        end else if (revertive_i && (prio_a[best_w] > prio_a[st_q.sel])) begin
            st_d.sel = best_w;
        end
        st_d.pulse = (st_d.sel != st_q.sel);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.sel   <= '0;
            st_q.hold  <= 1'b1;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_idx_o      = st_q.sel;
    assign ref_lost_o     = lost_w;
    assign holdover_o     = st_q.hold;
    assign switch_pulse_o = st_q.pulse;

    a_r4_sel_is_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_d.hold |-> qual_w[st_d.sel]);
    a_r7_none_means_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (qual_w == '0) |=> (st_q.hold && $stable(st_q.sel)));
    a_r8_nonrevert_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!revertive_i && !st_q.hold && qual_w[st_q.sel]) |=> $stable(st_q.sel));
    a_r9_pulse_marks_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (st_q.pulse == (st_q.sel != $past(st_q.sel))));
endmodule

// File: tb/refmon_select_tb_top.sv
module refmon_select_tb_top;
    localparam int NR = 4;
    localparam int CW = 16;
    localparam int QW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] ref_edge = '0;
    logic [NR-1:0] ref_en = '1;
    logic [NR*CW-1:0] lim;
    logic [NR*2-1:0]  prio;
    logic [QW-1:0] qual = 4'd3;
    logic          revert = 1'b0;
    logic [1:0]    sel_idx;
    logic [NR-1:0] lost;
    logic          hold;
    logic          pulse;

    int checks = 0;
    int fails = 0;
    int per [NR];
    int ph [NR];
    bit cmp_on = 1'b0;
    bit done = 1'b0;
    int cyc = 0;
    int pulses = 0;
    int changes = 0;
    logic [1:0] last_sel = '0;

    // behavioural reference state
    int mcnt [NR];
    int mgood [NR];
    int mlost [NR];
    int msel = 0;
    int mhold = 1;
    int mpulse = 0;
    int best, bp, nsel, nhold, q;

    always #4 clk = ~clk;

    refmon_select dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ref_edge_i(ref_edge), .ref_en_i(ref_en),
        .ref_limit_i(lim), .ref_prio_i(prio), .qual_edges_i(qual),
        .revertive_i(revert), .sel_idx_o(sel_idx), .ref_lost_o(lost),
        .holdover_o(hold), .switch_pulse_o(pulse)
    );

    function automatic int pr(int i);
        return int'(prio[i*2 +: 2]);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) begin
                mcnt[i] = 0; mgood[i] = 0; mlost[i] = 1;
            end
            msel = 0; mhold = 1; mpulse = 0;
        end else begin
            best = -1; bp = -1;
            for (int i = 0; i < NR; i++)
                if (ref_en[i] && mlost[i] == 0 && pr(i) > bp) begin
                    best = i; bp = pr(i);
                end
            nsel = msel; nhold = mhold;
            if (best < 0) nhold = 1;
            else if (mhold == 1 || !(ref_en[msel] && mlost[msel] == 0)) begin
                nsel = best; nhold = 0;
            end else if (revert && bp > pr(msel)) nsel = best;
            mpulse = (nsel != msel) ? 1 : 0;
            msel = nsel; mhold = nhold;
            q = (int'(qual) == 0) ? 1 : int'(qual);
            for (int i = 0; i < NR; i++) begin
                if (!ref_en[i]) begin
                    mcnt[i] = 0; mgood[i] = 0; mlost[i] = 1;
                end else if (ref_edge[i]) begin
                    mcnt[i] = 0;
                    if (mlost[i] == 1) begin
                        mgood[i]++;
                        if (mgood[i] >= q) begin mlost[i] = 0; mgood[i] = 0; end
                    end
                end else if (mcnt[i] + 1 >= int'(lim[i*CW +: CW])) begin
                    mcnt[i] = int'(lim[i*CW +: CW]); mlost[i] = 1; mgood[i] = 0;
                end else mcnt[i]++;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            for (int i = 0; i < NR; i++) chk("R2/R3 loss flag", int'(lost[i]), mlost[i]);
            chk("R5/R6 selected index", int'(sel_idx), msel);
            chk("R7 holdover", int'(hold), mhold);
            chk("R9 switch pulse", int'(pulse), mpulse);
            if (pulse) pulses++;
            if (sel_idx != last_sel) changes++;
            last_sel = sel_idx;
        end
        for (int i = 0; i < NR; i++) begin
            if (per[i] == 0) begin
                ph[i] = 0; ref_edge[i] = 1'b0;
            end else begin
                ph[i]++;
                if (ph[i] >= per[i]) begin ref_edge[i] = 1'b1; ph[i] = 0; end
                else ref_edge[i] = 1'b0;
            end
        end
    end

    task automatic wait_cyc(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < NR; i++) begin
            per[i] = 0; ph[i] = 0; lim[i*CW +: CW] = 16'd12;
        end
        prio = {2'd0, 2'd3, 2'd3, 2'd1};
        wait_cyc(3);
        chk("R1 reset loss flags", int'(lost), 15);
        chk("R1 reset holdover", int'(hold), 1);
        chk("R1 reset index", int'(sel_idx), 0);
        chk("R1 reset pulse", int'(pulse), 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // all four running; input 3 period equals its limit
        per[0] = 8; per[1] = 8; per[2] = 10; per[3] = 12;
        wait_cyc(120);
        chk("R7 holdover left", int'(hold), 0);
        chk("R10 period equal to limit not lost", int'(lost[3]), 0);
        chk("R5 best priority chosen", int'(sel_idx), 1);
        // active input stops
        per[1] = 0;
        wait_cyc(40);
        chk("R2 silent input flagged", int'(lost[1]), 1);
        chk("R6 switch to next best", int'(sel_idx), 2);
        // input 1 recovers, non-revertive
        per[1] = 8;
        wait_cyc(60);
        chk("R3 requalified", int'(lost[1]), 0);
        chk("R8 non-revertive stays", int'(sel_idx), 2);
        // revertive with input 1 strictly higher
        prio[5:4] = 2'd2;
        revert = 1'b1;
        wait_cyc(20);
        chk("R8 revertive returns", int'(sel_idx), 1);
        // limit one below the period
        lim[3*CW +: CW] = 16'd11;
        wait_cyc(40);
        chk("R2 limit below period flags", int'(lost[3]), 1);
        // disable the active input
        ref_en[1] = 1'b0;
        wait_cyc(20);
        chk("R4 disabled flagged", int'(lost[1]), 1);
        chk("R4 disabled not selected", int'(sel_idx), 2);
        // everything silent
        ref_en[1] = 1'b1;
        per[0] = 0; per[1] = 0; per[2] = 0; per[3] = 0;
        wait_cyc(40);
        chk("R7 holdover entered", int'(hold), 1);
        chk("R7 index held", int'(sel_idx), 2);
        chk("R4 all flagged", int'(lost), 15);
        // two equal-priority inputs requalify together
        prio[5:4] = 2'd3;
        per[1] = 8; per[2] = 8;
        wait_cyc(60);
        chk("R5 tie goes to lower index", int'(sel_idx), 1);
        chk("R7 holdover left again", int'(hold), 0);
        chk("R9 pulses match changes", pulses, changes);
        chk("R9 pulses seen", int'(pulses > 0), 1);
        finish_run();
    end

    initial begin
        wait_cyc(50000);
        fails++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end
endmodule